// File: doc/BRIEF.md
# Two-Digit Decimal Rate Multiplier

This block turns a stream of enabled clock cycles into a thinner stream of single-cycle pulses. Each stage holds a decade counter that steps once per enabled cycle. A 4-bit BCD digit picks which counter states produce an output pulse. A stage programmed with digit N therefore produces N pulses in every ten enabled cycles. The pulses are spread over the decade instead of being bunched together.

Two stages are built in, and a run-time mode input chooses how they are chained. In summing mode, the upper stage's end-of-decade pulse enables the lower stage, and the two pulse streams are merged. The rate is then the clock rate times (D_hi/10 + D_lo/100). In product mode, the upper stage's pulses enable the lower stage, and only the lower stage drives the output. The rate is then the clock rate times (D_hi/10)·(D_lo/10).

A shared preload control puts both decade counters into state nine. Each stage also reports when it sits in state nine. The lower stage's end-of-decade pulse is brought out so that further digits can be hung below this pair.

Top module: `rm_rate_pair`

## Requirements
- R1: While `rst` is high at a clock edge, both decade counters go to state 0 and every registered output goes low. `rst` takes priority over `preset_nine`.
- R2: Each decade counter advances by one only on cycles in which its enable is high and `preset_nine` is low. It counts 0,1,…,9 and then wraps to 0. With its enable low, it holds its state.
- R3: A stage whose enable is high in a cycle produces a pulse on its registered pulse output in the next cycle, provided its counter state is in a slot selected by its digit. The slot sets are: digit bit 0 selects state 5; bit 1 selects states 3 and 8; bit 2 selects states 2, 4, 7 and 9; bit 3 selects every state except 0 and 5. State 0 is never selected. A digit N from 0 to 9 yields exactly N pulses per ten enabled cycles.
- R4: Any digit value from 10 to 15 behaves exactly as 9.
- R5: `preset_nine` high at a clock edge (without `rst`) loads both counters with 9. In that cycle, neither stage pulses nor signals end of decade.
- R6: `nine_hi` and `nine_lo` are high exactly while the upper and lower counters, respectively, hold state 9.
- R7: `carry_out` is high for one cycle, in the cycle after the lower counter wraps from 9 to 0.
- R8: With `mult_mode` = 0, the lower stage is enabled by the upper stage's end-of-decade pulse. `pulse_out` is the OR of the two stage pulses, registered once more. Over 100 enabled cycles from reset, `pulse_out` gives 10·D_hi + D_lo pulses, and the two stage pulses never coincide.
- R9: With `mult_mode` = 1, the lower stage is enabled by the upper stage's pulse output, and `pulse_out` is the lower stage pulse registered once more. Over 100 enabled cycles from reset, it gives D_hi·D_lo pulses.
- R10: `hi_pulse` carries the upper stage's registered pulse. It gives 10·D_hi pulses over 100 enabled cycles from reset, in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Count enable for the upper stage |
| mult_mode | input | 1 | 0 = summing chain, 1 = product chain |
| preset_nine | input | 1 | Load both counters with 9 |
| digit_hi | input | 4 | BCD digit of the upper (more significant) stage |
| digit_lo | input | 4 | BCD digit of the lower stage |
| pulse_out | output | 1 | Combined output pulse stream |
| hi_pulse | output | 1 | Upper stage pulse stream |
| nine_hi | output | 1 | Upper counter holds 9 |
| nine_lo | output | 1 | Lower counter holds 9 |
| carry_out | output | 1 | Lower stage end-of-decade pulse |

## Verification
The hardest situation to reach is the lower stage's own wrap. That stage is never driven directly. It only steps when the upper stage finishes a decade in summing mode, or when the upper stage pulses in product mode. Its nine flag and `carry_out` only move after ten or more upper-stage events. The bench uses the preload to put both counters at nine. A single enabled cycle then sets off the chained wrap, and the bench checks the lower nine flag and `carry_out` at their exact cycles. The pulse counts are swept over all 256 digit pairs in both modes, plus a gapped-enable pattern. The expected values 10·D_hi + D_lo and D_hi·D_lo are computed from the clamped digits.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam int DIGIT_W = 4;
  localparam int DECADE  = 10;
  localparam int STATE_W = $clog2(DECADE);
  localparam int LAST    = DECADE - 1;

  typedef logic [DECADE-1:0] slot_mask_t;

  // Slot set per BCD weight; sets 0..2 are mutually disjoint, set 3 is
  // disjoint from set 0, and state 0 is absent from all of them.
  function automatic slot_mask_t weight_slots(input int bit_idx);
    case (bit_idx)
      0:       return slot_mask_t'(10'b00_0010_0000);
      1:       return slot_mask_t'(10'b01_0000_1000);
      2:       return slot_mask_t'(10'b10_1001_0100);
      default: return slot_mask_t'(10'b11_1101_1110);
    endcase
  endfunction

  function automatic logic [DIGIT_W-1:0] clamp_digit(input logic [DIGIT_W-1:0] d);
    return (d > DIGIT_W'(LAST)) ? DIGIT_W'(LAST) : d;
  endfunction
endpackage

// File: rtl/rm_decade_counter.sv
module rm_decade_counter
  import rm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               preset,
  output logic [STATE_W-1:0] state,
  output logic               wrap,
  output logic               at_last
);
  assign at_last = (state == STATE_W'(LAST));
  assign wrap    = en && !preset && at_last;

  always_ff @(posedge clk) begin
    if (rst)          state <= '0;
    else if (preset)  state <= STATE_W'(LAST);
    else if (en)      state <= at_last ? '0 : state + 1'b1;
  end

  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (rst)
    state <= STATE_W'(LAST));                                       // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!en && !preset) |=> $stable(state));                           // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (en && !preset && state == STATE_W'(LAST)) |=> state == '0);    // R2
  AST_PRESET_NINE: assert property (@(posedge clk) disable iff (rst)
    preset |=> state == STATE_W'(LAST));                            // R5
endmodule

// File: rtl/rm_slot_gate.sv
module rm_slot_gate
  import rm_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  input  logic [STATE_W-1:0] state,
  output logic               hit
);
  logic [DIGIT_W-1:0] bit_hit;

  for (genvar b = 0; b < DIGIT_W; b++) begin : g_weight
    localparam slot_mask_t SLOTS = weight_slots(b);
    assign bit_hit[b] = digit[b] && (state <= STATE_W'(LAST)) && SLOTS[state];
  end

  assign hit = |bit_hit;
endmodule

// File: rtl/rm_stage.sv
module rm_stage
  import rm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               preset,
  input  logic [DIGIT_W-1:0] digit,
  output logic               pulse_q,
  output logic               carry_q,
  output logic               nine
);
  logic [STATE_W-1:0] state;
  logic               wrap;
  logic               hit;
  logic [DIGIT_W-1:0] digit_c;

  assign digit_c = clamp_digit(digit);

  rm_decade_counter i_counter (
    .clk(clk), .rst(rst), .en(en), .preset(preset),
    .state(state), .wrap(wrap), .at_last(nine)
  );

  rm_slot_gate i_gate (
    .digit(digit_c), .state(state), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      pulse_q <= en && !preset && hit;
      carry_q <= wrap;
    end
  end

  AST_SLOT0_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == '0) |=> !pulse_q);                                    // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!en || preset) |=> !pulse_q);                                  // R3
  AST_CARRY_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    carry_q |=> !carry_q);                                          // R7
endmodule

// File: rtl/rm_rate_pair.sv
module rm_rate_pair
  import rm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               clk_en,
  input  logic               mult_mode,
  input  logic               preset_nine,
  input  logic [DIGIT_W-1:0] digit_hi,
  input  logic [DIGIT_W-1:0] digit_lo,
  output logic               pulse_out,
  output logic               hi_pulse,
  output logic               nine_hi,
  output logic               nine_lo,
  output logic               carry_out
);
  logic hi_carry;
  logic lo_pulse;
  logic lo_en;

  rm_stage i_hi (
    .clk(clk), .rst(rst), .en(clk_en), .preset(preset_nine),
    .digit(digit_hi), .pulse_q(hi_pulse), .carry_q(hi_carry), .nine(nine_hi)
  );

  assign lo_en = mult_mode ? hi_pulse : hi_carry;

  rm_stage i_lo (
    .clk(clk), .rst(rst), .en(lo_en), .preset(preset_nine),
    .digit(digit_lo), .pulse_q(lo_pulse), .carry_q(carry_out), .nine(nine_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) pulse_out <= 1'b0;
    else     pulse_out <= mult_mode ? lo_pulse : (hi_pulse || lo_pulse);
  end

  // Cycles spent in summing mode, saturating; used by the checks below.
  logic [1:0] add_run;
  always_ff @(posedge clk) begin
    if (rst || mult_mode)  add_run <= '0;
    else if (add_run != 2'd3) add_run <= add_run + 1'b1;
  end

  AST_NO_COINCIDE: assert property (@(posedge clk) disable iff (rst)
    (add_run >= 2'd2) |-> !(hi_pulse && lo_pulse));                 // R8
  AST_MULT_FOLLOWS_LO: assert property (@(posedge clk) disable iff (rst)
    (mult_mode && lo_pulse) |=> pulse_out);                         // R9
  AST_LO_GATED_BY_HI: assert property (@(posedge clk) disable iff (rst)
    (mult_mode && !hi_pulse && !preset_nine) |=> $stable(nine_lo));  // R9
endmodule

// File: tb/test_rm_rate_pair.sv
module test_rm_rate_pair;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_en = 1'b0;
  logic mult_mode = 1'b0;
  logic preset_nine = 1'b0;
  logic [3:0] digit_hi = '0;
  logic [3:0] digit_lo = '0;
  logic pulse_out, hi_pulse, nine_hi, nine_lo, carry_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rm_rate_pair i_rm_rate_pair (
    .clk(clk), .rst(rst), .clk_en(clk_en), .mult_mode(mult_mode),
    .preset_nine(preset_nine), .digit_hi(digit_hi), .digit_lo(digit_lo),
    .pulse_out(pulse_out), .hi_pulse(hi_pulse), .nine_hi(nine_hi),
    .nine_lo(nine_lo), .carry_out(carry_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual cycles=%0d expected <=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; clk_en = 1'b0; preset_nine = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int clampd(input int d);
    return (d > 9) ? 9 : d;
  endfunction

  // Runs 100 enabled cycles (optionally gapped) plus a flush, counting pulses.
  task automatic run_case(input int dh, input int dl, input bit mm, input bit gapped);
    int out_cnt = 0;
    int hi_cnt = 0;
    int en_cnt = 0;
    int phase = 0;
    int exp_out;
    mult_mode = mm;
    digit_hi = 4'(dh);
    digit_lo = 4'(dl);
    do_reset();
    while (en_cnt < 100) begin
      phase++;
      clk_en = gapped ? phase[0] : 1'b1;
      if (clk_en) en_cnt++;
      @(negedge clk);
      out_cnt += int'(pulse_out);
      hi_cnt  += int'(hi_pulse);
    end
    clk_en = 1'b0;
    repeat (6) begin
      @(negedge clk);
      out_cnt += int'(pulse_out);
      hi_cnt  += int'(hi_pulse);
    end
    exp_out = mm ? clampd(dh) * clampd(dl) : 10 * clampd(dh) + clampd(dl);
    if (mm) check($sformatf("R9 mult d=%0d,%0d", dh, dl), out_cnt, exp_out);
    else    check($sformatf("R8 add d=%0d,%0d gap=%0d", dh, dl, gapped), out_cnt, exp_out);
    check($sformatf("R10 hi d=%0d mode=%0d", dh, mm), hi_cnt, 10 * clampd(dh));
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check("R1 pulse_out", int'(pulse_out), 0);
    check("R1 hi_pulse", int'(hi_pulse), 0);
    check("R1 nine_hi", int'(nine_hi), 0);
    check("R1 nine_lo", int'(nine_lo), 0);
    check("R1 carry_out", int'(carry_out), 0);

    // R1 reset beats preset
    @(negedge clk); rst = 1'b1; preset_nine = 1'b1;
    @(negedge clk); check("R1 reset over preset", int'(nine_hi), 0);
    rst = 1'b0; preset_nine = 1'b0;

    // R2 count to nine, hold, wrap
    do_reset();
    clk_en = 1'b1;
    repeat (9) @(negedge clk);
    clk_en = 1'b0;
    check("R2 reach nine", int'(nine_hi), 1);
    repeat (3) @(negedge clk);
    check("R2 hold when idle", int'(nine_hi), 1);
    clk_en = 1'b1;
    @(negedge clk);
    clk_en = 1'b0;
    check("R2 wrap to zero", int'(nine_hi), 0);

    // R3 slot 0 quiet, slot 1 active for digit 8; R4 digit 15 at slot 0
    for (int d = 8; d < 16; d += 7) begin
      digit_hi = 4'(d);
      do_reset();
      clk_en = 1'b1;
      @(negedge clk);
      check($sformatf("R3 slot0 quiet d=%0d", d), int'(hi_pulse), 0);
      @(negedge clk);
      check($sformatf("R3 slot1 d=%0d", d), int'(hi_pulse), 1);
      clk_en = 1'b0;
    end

    // R5 preset suppresses pulse; R6/R7 chained wrap in summing mode
    digit_hi = 4'd9; mult_mode = 1'b0;
    do_reset();
    clk_en = 1'b1;
    @(negedge clk);
    preset_nine = 1'b1;
    @(negedge clk);
    check("R5 preset no pulse", int'(hi_pulse), 0);
    check("R6 nine_hi after preset", int'(nine_hi), 1);
    check("R6 nine_lo after preset", int'(nine_lo), 1);
    preset_nine = 1'b0;
    @(negedge clk);
    clk_en = 1'b0;
    check("R6 nine_hi cleared", int'(nine_hi), 0);
    check("R6 nine_lo held", int'(nine_lo), 1);
    check("R7 no carry yet", int'(carry_out), 0);
    @(negedge clk);
    check("R6 nine_lo cleared", int'(nine_lo), 0);
    check("R7 carry pulse", int'(carry_out), 1);
    @(negedge clk);
    check("R7 carry one wide", int'(carry_out), 0);

    // R4 R8 R9 R10 exhaustive digit sweep in both modes
    for (int m = 0; m < 2; m++)
      for (int dh = 0; dh < 16; dh++)
        for (int dl = 0; dl < 16; dl++)
          run_case(dh, dl, m[0], 1'b0);

    // R2 R8 gapped enable
    run_case(7, 3, 1'b0, 1'b1);
    run_case(9, 9, 1'b0, 1'b1);
    run_case(5, 6, 1'b1, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule